// File: doc/BRIEF.md
# FIFO Depth-Cascade Token Controller

This block is the pointer and ownership logic for one slice of a FIFO built from several identical slices chained in depth. Two independent tokens travel around a ring of slices: one grants the right to accept writes, the other the right to deliver reads. Only the slice that holds a token advances the matching pointer.

When the holder performs an operation at the last address of its slice, it hands the token to the next slice with a one-cycle pulse on its expansion output. It then freezes that pointer until a pulse on its expansion input brings the token back. When the token returns, the pointer restarts at zero.

When cascading is turned off, a slice keeps both tokens for good and its pointers simply wrap. The memory array, the data paths and the occupancy flags are outside this block.

Each side is a two-state machine. In `TK_HELD` the side owns its token and counts enabled operations. In `TK_AWAY` the token is elsewhere and the pointer is frozen. The transition *pass* (`TK_HELD` to `TK_AWAY`) happens on an enabled operation at the last address in cascade mode. The transition *regain* (`TK_AWAY` to `TK_HELD`) happens on an expansion-input pulse and clears the pointer. In `TK_HELD` an enabled operation at the last address with cascading off takes the *wrap* self-transition.

Top module: `fifo_chain_token_ctrl`

## Requirements
- R1: After reset, a slice with `first_dev`=1, or any slice with `cascade_en`=0, holds both tokens. Any other slice holds neither. Both pointers are 0.
- R2: With `cascade_en`=0, each enabled operation adds one to the pointer, DEPTH-1 is followed by 0, and the expansion outputs stay 0.
- R3: With `cascade_en`=1, an enabled operation by the token holder at address DEPTH-1 raises that side's expansion output in the same cycle, for exactly one cycle. At the next edge the side releases its token and its pointer stays at DEPTH-1.
- R4: A side that does not hold its token ignores its enable. Its pointer does not change and its expansion output stays 0.
- R5: A pulse on a side's expansion input while that side does not hold its token gives the token back at the next edge, with the pointer set to 0.
- R6: The read side and the write side are fully independent. Each has its own enable, token, pointer and expansion pins.
- R7: In a ring of cascaded slices, where each slice's expansion output feeds the next slice's expansion input, exactly one slice holds each token at every cycle. The token moves in ring order.
- R8: A token holder below address DEPTH-1 adds one to its pointer per enabled operation and keeps its expansion output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cascade_en | input | 1 | 1 = depth-cascade mode, 0 = stand-alone wrap mode (static) |
| first_dev | input | 1 | 1 = this slice holds both tokens after reset (static) |
| wr_en | input | 1 | Write operation this cycle |
| rd_en | input | 1 | Read operation this cycle |
| wr_xin | input | 1 | Write token arriving from the previous slice |
| rd_xin | input | 1 | Read token arriving from the previous slice |
| wr_xout | output | 1 | Write token handed to the next slice |
| rd_xout | output | 1 | Read token handed to the next slice |
| wr_ptr | output | $clog2(DEPTH) | Write address pointer |
| rd_ptr | output | $clog2(DEPTH) | Read address pointer |
| wr_held | output | 1 | This slice owns the write token |
| rd_held | output | 1 | This slice owns the read token |

## Verification
A wrong held state shows at the ports within one cycle. Either two slices report holding the same token, or none does. An expansion pulse goes missing or appears twice, and in the next cycle the following slice either fails to take the token or takes it while it already holds it. A pointer that counts while it should be frozen, or a regain that fails to clear it, shows as a pointer value that differs from the reference at the very next edge. Comparing every output on every clock therefore places the fault in the cycle it occurs.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
    typedef enum logic [0:0] {
        TK_HELD = 1'b0,
        TK_AWAY = 1'b1
    } tk_state_e;
endpackage

// File: rtl/fifo_token_side.sv
module fifo_token_side
    import fifo_chain_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cascade_en,
    input  logic             first_dev,
    input  logic             en,
    input  logic             exp_in,
    output logic             exp_out,
    output logic [PTR_W-1:0] ptr,
    output logic             held
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    tk_state_e        state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             at_last, fire;

    assign at_last = (ptr_q == LAST);
    assign fire    = (state_q == TK_HELD) && en;

    // next-state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            TK_HELD: begin
                if (fire) begin
                    if (!at_last) begin
                        ptr_d = ptr_q + 1'b1;
                    end else if (cascade_en) begin
                        state_d = TK_AWAY;      // pass
                    end else begin
                        ptr_d = '0;             // wrap
                    end
                end
            end
            TK_AWAY: begin
                if (exp_in) begin
                    state_d = TK_HELD;          // regain
                    ptr_d   = '0;
                end
            end
            default: state_d = TK_AWAY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= (first_dev || !cascade_en) ? TK_HELD : TK_AWAY;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        exp_out = cascade_en && fire && at_last;
        held    = (state_q == TK_HELD);
        ptr     = ptr_q;
    end

    // R3: hand-off pulse lasts one cycle and the token is gone afterwards
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        exp_out |=> (!exp_out && !held && ptr == LAST));
    // R4: a side without its token and no incoming token keeps its pointer
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !exp_in) |=> ($stable(ptr) && !held));
    // R4: no hand-off pulse without the token
    a_r4_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> !exp_out);
    // R5: returning token restarts the pointer at zero
    a_r5_regain: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && exp_in) |=> (held && ptr == '0));
    // R2: stand-alone mode wraps and never signals
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_en && held && en && ptr == LAST) |=> (held && ptr == '0));
    // R8: holder below the last address counts by one
    a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
        (held && en && ptr != LAST) |=> (held && ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/fifo_chain_token_ctrl.sv
module fifo_chain_token_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cascade_en,
    input  logic             first_dev,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             wr_xin,
    input  logic             rd_xin,
    output logic             wr_xout,
    output logic             rd_xout,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             wr_held,
    output logic             rd_held
);
    // R6: two independent sides
    fifo_token_side #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .first_dev(first_dev),
        .en(wr_en), .exp_in(wr_xin), .exp_out(wr_xout), .ptr(wr_ptr), .held(wr_held)
    );

    fifo_token_side #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .first_dev(first_dev),
        .en(rd_en), .exp_in(rd_xin), .exp_out(rd_xout), .ptr(rd_ptr), .held(rd_held)
    );

    // R1: reset ownership follows the first-slice and mode selects
    a_r1_reset_own: assert property (@(posedge clk)
        (!rst_n) |=> (wr_held == (first_dev || !cascade_en) && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: tb/sim_fifo_chain_token_ctrl.sv
module sim_fifo_chain_token_ctrl;
    localparam int DEPTH = 8;
    localparam int LAST  = DEPTH - 1;
    localparam int N     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic casc = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [N-1:0] wxo, rxo, wheld, rheld;
    logic [2:0] wptr [N];
    logic [2:0] rptr [N];

    int checks = 0, errors = 0;
    bit m_tok [2][N];
    int m_ptr [2][N];
    bit m_xo  [2][N];

    always #2.5 clk = ~clk;

    fifo_chain_token_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cascade_en(casc), .first_dev(1'b1),
        .wr_en(wr_en), .rd_en(rd_en), .wr_xin(wxo[2]), .rd_xin(rxo[2]),
        .wr_xout(wxo[0]), .rd_xout(rxo[0]), .wr_ptr(wptr[0]), .rd_ptr(rptr[0]),
        .wr_held(wheld[0]), .rd_held(rheld[0]));
    fifo_chain_token_ctrl #(.DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n), .cascade_en(casc), .first_dev(1'b0),
        .wr_en(wr_en), .rd_en(rd_en), .wr_xin(wxo[0]), .rd_xin(rxo[0]),
        .wr_xout(wxo[1]), .rd_xout(rxo[1]), .wr_ptr(wptr[1]), .rd_ptr(rptr[1]),
        .wr_held(wheld[1]), .rd_held(rheld[1]));
    fifo_chain_token_ctrl #(.DEPTH(DEPTH)) u2 (
        .clk(clk), .rst_n(rst_n), .cascade_en(casc), .first_dev(1'b0),
        .wr_en(wr_en), .rd_en(rd_en), .wr_xin(wxo[1]), .rd_xin(rxo[1]),
        .wr_xout(wxo[2]), .rd_xout(rxo[2]), .wr_ptr(wptr[2]), .rd_ptr(rptr[2]),
        .wr_held(wheld[2]), .rd_held(rheld[2]));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < N; d++) begin
                m_tok[s][d] = (d == 0) || !casc;
                m_ptr[s][d] = 0;
                m_xo[s][d]  = 1'b0;
            end
    endtask

    task automatic model_xo(input bit we, input bit re);
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < N; d++)
                m_xo[s][d] = casc && m_tok[s][d] && (s == 0 ? we : re) && m_ptr[s][d] == LAST;
    endtask

    task automatic model_step(input bit we, input bit re);
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < N; d++) begin
                if (m_tok[s][d]) begin
                    if (s == 0 ? we : re) begin
                        if (m_ptr[s][d] != LAST) m_ptr[s][d]++;
                        else if (casc) m_tok[s][d] = 1'b0;
                        else m_ptr[s][d] = 0;
                    end
                end else if (m_xo[s][(d + N - 1) % N]) begin
                    m_tok[s][d] = 1'b1;
                    m_ptr[s][d] = 0;
                end
            end
    endtask

    task automatic compare();
        int nw, nr;
        nw = 0; nr = 0;
        for (int d = 0; d < N; d++) begin
            check(wheld[d] == m_tok[0][d], "R7 wr token", wheld[d], m_tok[0][d]);
            check(rheld[d] == m_tok[1][d], "R7 rd token", rheld[d], m_tok[1][d]);
            check(int'(wptr[d]) == m_ptr[0][d], "R8 wr ptr", wptr[d], m_ptr[0][d]);
            check(int'(rptr[d]) == m_ptr[1][d], "R8 rd ptr", rptr[d], m_ptr[1][d]);
            check(wxo[d] == m_xo[0][d], "R3 wr xout", wxo[d], m_xo[0][d]);
            check(rxo[d] == m_xo[1][d], "R3 rd xout", rxo[d], m_xo[1][d]);
            nw += int'(wheld[d]);
            nr += int'(rheld[d]);
        end
        if (casc) begin
            check(nw == 1, "R7 single wr holder", nw, 1);
            check(nr == 1, "R7 single rd holder", nr, 1);
        end
    endtask

    task automatic cycle(input bit we, input bit re);
        wr_en = we;
        rd_en = re;
        model_xo(we, re);
        #1 compare();
        @(posedge clk);
        model_step(we, re);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit c);
        rst_n = 1'b0;
        casc = c;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        do_reset(1'b1);
        // R1 reset ownership
        check(wheld == 3'b001, "R1 wr holders", wheld, 1);
        check(rheld == 3'b001, "R1 rd holders", rheld, 1);
        check(wptr[0] == 0 && rptr[0] == 0, "R1 ptrs", wptr[0], 0);
        // R6: writes only leave read side untouched
        repeat (3) cycle(1'b1, 1'b0);
        check(wptr[0] == 3, "R6 wr ptr", wptr[0], 3);
        check(rptr[0] == 0 && rheld[0], "R6 rd ptr untouched", rptr[0], 0);
        // write to handoff
        repeat (5) cycle(1'b1, 1'b0);
        check(!wheld[0] && wptr[0] == 7, "R3 released and frozen", wptr[0], 7);
        check(wheld[1] && wptr[1] == 0, "R5 u1 regained", wptr[1], 0);
        // R4: enables on u0 write side are ignored now
        repeat (4) cycle(1'b1, 1'b0);
        check(wptr[0] == 7 && !wheld[0], "R4 u0 frozen", wptr[0], 7);
        // full ring back to u0
        repeat (12) cycle(1'b1, 1'b0);
        check(wheld[0] && wptr[0] == 0, "R5 u0 regained", wptr[0], 0);
        check(wptr[2] == 7 && !wheld[2], "R7 u2 passed", wptr[2], 7);
        // mixed traffic
        lfsr = 8'h5a;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cycle(lfsr[0], lfsr[3]);
        end
        // stand-alone mode
        do_reset(1'b0);
        check(wheld == 3'b111 && rheld == 3'b111, "R1 non-cascade holders", wheld, 7);
        repeat (10) cycle(1'b1, 1'b0);
        check(wptr[1] == 2 && wheld[1], "R2 wrap", wptr[1], 2);
        check(wxo == 3'b000, "R2 no xout", wxo, 0);
        repeat (20) cycle(1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule